// File: doc/BRIEF.md
# Two-Slot Lock-Step Bundle Core

This block is a small in-order processor core. Each cycle it fetches one 64-bit bundle that holds two 32-bit instructions. Both instructions issue together and retire together. The low word is slot 0, which accepts only integer ALU operations and conditional branches. The high word is slot 1, which accepts only word loads and stores. The block does not check whether the two instructions are independent. The code generator must schedule independent pairs, fill unused slots with no-ops, and keep a consumer at least one bundle after the load that feeds it.

Each slot has its own execution hardware. Slot 0 has an ALU and a branch comparator. Slot 1 has a separate adder that forms the address as base plus sign-extended offset. A shared register file serves both slots with four read ports and two write ports. The instruction array and the data array are inside the block. Both can be filled through a host write port, which is normally used while reset is held. Committed stores appear on a registered trace output, so the surrounding logic can follow the program's memory effects. A stall input freezes the whole machine for as long as it is held high.

Top module: `vliw2_core`

## Requirements
- R1: While `rst` is high, `store_valid` is 0. After `rst` falls, execution starts at bundle address 0. Without a taken branch or a stall, each new bundle is 8 bytes past the previous one. Host writes to both arrays take effect whether or not reset is active, and reset does not clear the arrays.
- R2: Slot 0 (bits 31:0) executes these R-format operations (opcode 0, shift field 0): addu (function 0x21), subu (0x23), and (0x24), or (0x25) and signed slt (0x2A). It also executes addi (opcode 0x08), which adds a sign-extended immediate and writes rt.
- R3: Slot 1 (bits 63:32) executes lw (opcode 0x23) and sw (opcode 0x2B). The byte address is rs plus the sign-extended 16-bit offset, and bits 1:0 of the address are ignored for the array index. A store shows on `store_valid`/`store_addr`/`store_data` on the cycle after its bundle executes.
- R4: Both slots read their operands before either slot writes. A store in slot 1 sees the value a register held before the bundle, even when slot 0 of the same bundle writes that register.
- R5: A loaded value is visible to the very next bundle that executes, and to all bundles after it.
- R6: When a slot 0 write and a load write reach the same register, the load value is the one that remains. Writes to register 0 are dropped, and register 0 always reads as 0.
- R7: beq (opcode 0x04) and bne (opcode 0x05) in slot 0 compare rs with rt. When the branch is taken, the next bundle comes from the bundle address + 8 + offset×4. Offset bit 0 is ignored because bundles are 8-byte aligned. The sequential bundle that was already fetched is discarded, and the slot 1 instruction of the branch bundle still completes.
- R8: Any encoding that a slot does not accept acts as a no-op and changes no register, no memory word and no PC flow. This covers an unknown opcode, an R-format instruction with a nonzero shift field, a load or store in slot 0, and an ALU operation in slot 1.
- R9: While `stall` is high, no bundle executes, the PC and all pipeline state hold, and no store is reported on the next cycle. When `stall` falls, the program produces the same store sequence it produces without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freezes the PC and all pipeline state while high |
| im_we | input | 1 | Host write strobe for the instruction array |
| im_addr | input | IA_W | Bundle index for the host instruction write |
| im_wdata | input | 64 | Bundle written by the host |
| dm_we | input | 1 | Host write strobe for the data array |
| dm_addr | input | DA_W | Word index for the host data write |
| dm_wdata | input | 32 | Word written by the host |
| store_valid | output | 1 | A store was committed on the previous cycle |
| store_addr | output | 32 | Byte address of that store |
| store_data | output | 32 | Data of that store |

## Verification
The assertions rely on the host not writing the instruction array while the core is out of reset and running, because a bundle overwritten mid-fetch is outside the contract. They also rely on `stall` being a clean level sampled at the clock. The bench loads both arrays only while reset is high and drives `stall` only at the falling edge. The program is scheduled by hand so that no bundle breaks the independence rule, and it ends in a branch to itself so the PC never walks into arrays that were not loaded.

// File: rtl/vliw2_pkg.sv
package vliw2_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int NREG = 1 << RIDX;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_BNE   = 6'h05;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_NONE,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_sel_e;

  typedef struct packed {
    logic [5:0] op;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [4:0] sh;
    logic [5:0] fn;
  } instr_t;

endpackage

// File: rtl/vliw2_ram.sv
module vliw2_ram #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_we) mem[b_addr] <= b_wdata;
  end

endmodule

// File: rtl/vliw2_regfile.sv
module vliw2_regfile
  import vliw2_pkg::*;
#(
  parameter int NRD = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NRD-1:0][RIDX-1:0]  ra,
  output logic [NRD-1:0][XLEN-1:0]  rd,
  input  logic                      wa_en,
  input  logic [RIDX-1:0]           wa_idx,
  input  logic [XLEN-1:0]           wa_data,
  input  logic                      wb_en,
  input  logic [RIDX-1:0]           wb_idx,
  input  logic [XLEN-1:0]           wb_data
);

  logic [XLEN-1:0] rf_q [NREG];

  // Port b (late load result) is applied last, so it wins a same-index clash.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else begin
      if (wa_en && wa_idx != '0) rf_q[wa_idx] <= wa_data;
      if (wb_en && wb_idx != '0) rf_q[wb_idx] <= wb_data;
    end
  end

  // Port b bypasses into the reads; port a does not, so partners in a bundle
  // never see each other's results.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = (ra[g] == '0)                  ? '0      :
                   (wb_en && wb_idx == ra[g])     ? wb_data :
                                                    rf_q[ra[g]];
  end

  p_zero_reg_r6: assert property (@(posedge clk) disable iff (rst)
    rf_q[0] == '0);

endmodule

// File: rtl/vliw2_slot0.sv
module vliw2_slot0
  import vliw2_pkg::*;
(
  input  instr_t            ins,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic [RIDX-1:0]   src_s,
  output logic [RIDX-1:0]   src_t,
  output logic              wr_en,
  output logic [RIDX-1:0]   wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              br_take
);

  alu_sel_e        sel;
  logic            use_imm;
  logic            is_beq;
  logic            is_bne;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] rhs;
  logic [XLEN-1:0] diff;

  assign src_s  = ins.rs;
  assign src_t  = ins.rt;
  assign imm_sx = {{(XLEN-16){ins.rd[4]}}, ins.rd, ins.sh, ins.fn};

  always_comb begin
    sel     = ALU_NONE;
    use_imm = 1'b0;
    wr_idx  = ins.rd;
    is_beq  = 1'b0;
    is_bne  = 1'b0;
    if (ins.op == OPC_RTYPE && ins.sh == '0) begin
      unique case (ins.fn)
        FN_ADDU: sel = ALU_ADD;
        FN_SUBU: sel = ALU_SUB;
        FN_AND:  sel = ALU_AND;
        FN_OR:   sel = ALU_OR;
        FN_SLT:  sel = ALU_SLT;
        default: sel = ALU_NONE;
      endcase
    end else if (ins.op == OPC_ADDI) begin
      sel     = ALU_ADD;
      use_imm = 1'b1;
      wr_idx  = ins.rt;
    end else if (ins.op == OPC_BEQ) begin
      is_beq = 1'b1;
    end else if (ins.op == OPC_BNE) begin
      is_bne = 1'b1;
    end
  end

  assign rhs  = use_imm ? imm_sx : opb;
  assign diff = opa - rhs;

  always_comb begin
    unique case (sel)
      ALU_ADD: wr_data = opa + rhs;
      ALU_SUB: wr_data = diff;
      ALU_AND: wr_data = opa & rhs;
      ALU_OR:  wr_data = opa | rhs;
      ALU_SLT: wr_data = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(rhs))};
      default: wr_data = '0;
    endcase
  end

  assign wr_en   = (sel != ALU_NONE);
  assign br_take = (is_beq && diff == '0) || (is_bne && diff != '0);

endmodule

// File: rtl/vliw2_slot1.sv
module vliw2_slot1
  import vliw2_pkg::*;
(
  input  instr_t            ins,
  input  logic [XLEN-1:0]   base,
  output logic [RIDX-1:0]   src_s,
  output logic [RIDX-1:0]   src_t,
  output logic              is_ld,
  output logic              is_st,
  output logic [RIDX-1:0]   ld_idx,
  output logic [XLEN-1:0]   addr
);

  logic [XLEN-1:0] off_sx;

  assign src_s  = ins.rs;
  assign src_t  = ins.rt;
  assign is_ld  = (ins.op == OPC_LW);
  assign is_st  = (ins.op == OPC_SW);
  assign ld_idx = ins.rt;
  assign off_sx = {{(XLEN-16){ins.rd[4]}}, ins.rd, ins.sh, ins.fn};
  assign addr   = base + off_sx;

endmodule

// File: rtl/vliw2_core.sv
module vliw2_core
  import vliw2_pkg::*;
#(
  parameter int IA_W = 6,
  parameter int DA_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             im_we,
  input  logic [IA_W-1:0]  im_addr,
  input  logic [63:0]      im_wdata,
  input  logic             dm_we,
  input  logic [DA_W-1:0]  dm_addr,
  input  logic [31:0]      dm_wdata,
  output logic             store_valid,
  output logic [31:0]      store_addr,
  output logic [31:0]      store_data
);

  localparam int BW   = 2 * XLEN;
  localparam int NRDP = 4;

  // fetch / execute state, PC counted in bundles
  logic [IA_W-1:0] pc_q;
  logic [IA_W-1:0] x_pc_q;
  logic            x_vld_q;
  logic [BW-1:0]   ir;
  instr_t          ins0;
  instr_t          ins1;
  logic            x_go;

  // register file wiring
  logic [NRDP-1:0][RIDX-1:0] rf_ra;
  logic [NRDP-1:0][XLEN-1:0] rf_rd;

  // slot results
  logic [RIDX-1:0] s0_src_s, s0_src_t, s1_src_s, s1_src_t;
  logic            s0_wr_en, s0_take;
  logic [RIDX-1:0] s0_wr_idx;
  logic [XLEN-1:0] s0_wr_data;
  logic            s1_ld, s1_st;
  logic [RIDX-1:0] s1_ld_idx;
  logic [XLEN-1:0] s1_addr;

  // load writeback stage
  logic            ld_pend_q;
  logic [RIDX-1:0] ld_idx_q;
  logic [XLEN-1:0] dm_rdata;

  logic            take;
  logic [IA_W-1:0] target;

  assign ins0 = instr_t'(ir[XLEN-1:0]);
  assign ins1 = instr_t'(ir[BW-1:XLEN]);
  assign x_go = x_vld_q & ~stall;

  vliw2_ram #(.AW(IA_W), .DW(BW)) u_imem (
    .clk     (clk),
    .a_en    (~stall),
    .a_we    (1'b0),
    .a_addr  (pc_q),
    .a_wdata ({BW{1'b0}}),
    .a_rdata (ir),
    .b_we    (im_we),
    .b_addr  (im_addr),
    .b_wdata (im_wdata)
  );

  vliw2_slot0 u_slot0 (
    .ins     (ins0),
    .opa     (rf_rd[0]),
    .opb     (rf_rd[1]),
    .src_s   (s0_src_s),
    .src_t   (s0_src_t),
    .wr_en   (s0_wr_en),
    .wr_idx  (s0_wr_idx),
    .wr_data (s0_wr_data),
    .br_take (s0_take)
  );

  vliw2_slot1 u_slot1 (
    .ins    (ins1),
    .base   (rf_rd[2]),
    .src_s  (s1_src_s),
    .src_t  (s1_src_t),
    .is_ld  (s1_ld),
    .is_st  (s1_st),
    .ld_idx (s1_ld_idx),
    .addr   (s1_addr)
  );

  assign rf_ra[0] = s0_src_s;
  assign rf_ra[1] = s0_src_t;
  assign rf_ra[2] = s1_src_s;
  assign rf_ra[3] = s1_src_t;

  vliw2_regfile #(.NRD(NRDP)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra      (rf_ra),
    .rd      (rf_rd),
    .wa_en   (x_go & s0_wr_en),
    .wa_idx  (s0_wr_idx),
    .wa_data (s0_wr_data),
    .wb_en   (ld_pend_q & ~stall),
    .wb_idx  (ld_idx_q),
    .wb_data (dm_rdata)
  );

  vliw2_ram #(.AW(DA_W), .DW(XLEN)) u_dmem (
    .clk     (clk),
    .a_en    (x_go & (s1_ld | s1_st)),
    .a_we    (s1_st),
    .a_addr  (s1_addr[DA_W+1:2]),
    .a_wdata (rf_rd[3]),
    .a_rdata (dm_rdata),
    .b_we    (dm_we),
    .b_addr  (dm_addr),
    .b_wdata (dm_wdata)
  );

  // offset counts words; one bundle is two words, so drop offset bit 0
  assign take   = x_go & s0_take;
  assign target = x_pc_q + IA_W'(1) + IA_W'({{16{ir[15]}}, ir[15:1]});

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      x_pc_q  <= '0;
      x_vld_q <= 1'b0;
    end else if (!stall) begin
      x_pc_q <= pc_q;
      if (take) begin
        pc_q    <= target;
        x_vld_q <= 1'b0;
      end else begin
        pc_q    <= pc_q + IA_W'(1);
        x_vld_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_pend_q <= 1'b0;
      ld_idx_q  <= '0;
    end else if (!stall) begin
      ld_pend_q <= x_go & s1_ld;
      ld_idx_q  <= s1_ld_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_valid <= 1'b0;
      store_addr  <= '0;
      store_data  <= '0;
    end else begin
      store_valid <= x_go & s1_st;
      if (x_go && s1_st) begin
        store_addr <= s1_addr;
        store_data <= rf_rd[3];
      end
    end
  end

  p_seq_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!stall && !take) |=> (pc_q == IA_W'($past(pc_q) + IA_W'(1))));

  p_load_wb_r5: assert property (@(posedge clk) disable iff (rst)
    (x_go && s1_ld) |=> ld_pend_q);

  p_squash_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> !x_vld_q);

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_q));

  p_store_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> !store_valid);

endmodule

// File: tb/vliw2_core_tb.sv
`timescale 1ns/1ps
module vliw2_core_tb;

  localparam int IA_W = 6;
  localparam int DA_W = 8;

  localparam logic [5:0] T_RT   = 6'h00;
  localparam logic [5:0] T_BEQ  = 6'h04;
  localparam logic [5:0] T_BNE  = 6'h05;
  localparam logic [5:0] T_ADDI = 6'h08;
  localparam logic [5:0] T_LW   = 6'h23;
  localparam logic [5:0] T_SW   = 6'h2B;
  localparam logic [5:0] F_ADDU = 6'h21;
  localparam logic [5:0] F_SUBU = 6'h23;
  localparam logic [5:0] F_AND  = 6'h24;
  localparam logic [5:0] F_OR   = 6'h25;
  localparam logic [5:0] F_SLT  = 6'h2A;

  logic            clk = 1'b0;
  logic            rst;
  logic            stall;
  logic            im_we;
  logic [IA_W-1:0] im_addr;
  logic [63:0]     im_wdata;
  logic            dm_we;
  logic [DA_W-1:0] dm_addr;
  logic [31:0]     dm_wdata;
  logic            store_valid;
  logic [31:0]     store_addr;
  logic [31:0]     store_data;

  always #2.5 clk = ~clk;

  vliw2_core #(.IA_W(IA_W), .DA_W(DA_W)) u_dut (
    .clk(clk), .rst(rst), .stall(stall),
    .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .store_valid(store_valid), .store_addr(store_addr), .store_data(store_data)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       req;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  logic stall_seen = 1'b0;

  function automatic logic [31:0] rop(int rs, int rt, int rd, logic [5:0] fn);
    return {T_RT, 5'(rs), 5'(rt), 5'(rd), 5'h0, fn};
  endfunction

  function automatic logic [31:0] iop(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] d, input string req);
    exp_t e;
    e.a = a; e.d = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic im_put(input int idx, input logic [31:0] s0, input logic [31:0] s1);
    @(negedge clk);
    im_we = 1'b1; im_addr = IA_W'(idx); im_wdata = {s1, s0};
    @(negedge clk);
    im_we = 1'b0;
  endtask

  task automatic dm_put(input int idx, input logic [31:0] v);
    @(negedge clk);
    dm_we = 1'b1; dm_addr = DA_W'(idx); dm_wdata = v;
    @(negedge clk);
    dm_we = 1'b0;
  endtask

  task automatic push_program();
    push(32'd64, 32'd16,       "R3");
    push(32'd68, 32'd12,       "R5");
    push(32'd72, 32'hFFFFFFEF, "R2");
    push(32'd76, 32'd1,        "R2");
    push(32'd80, 32'd12,       "R2");
    push(32'd84, 32'd23,       "R4");
    push(32'd88, 32'hFFFFFFFD, "R6");
    push(32'd92, 32'd0,        "R6");
    push(32'd96, 32'd16,       "R7,R8");
    push(32'd104, 32'd3,       "R7");
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (q.size() != 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (30) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL %s: pending stores actual=%0d expected=0", req, q.size());
      q.delete();
    end
  endtask

  always @(posedge clk) stall_seen <= stall;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (stall_seen) begin
        total++;
        if (store_valid) begin
          bad++;
          $display("FAIL R9: store during stall actual=%0b expected=0", store_valid);
        end
      end
      if (store_valid) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R7: unexpected store actual=%0d/%h expected=none",
                   store_addr, store_data);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (store_addr !== e.a || store_data !== e.d) begin
            bad++;
            $display("FAIL %s: store actual=%0d/%h expected=%0d/%h",
                     e.req, store_addr, store_data, e.a, e.d);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R1: watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stall = 1'b0;
    im_we = 1'b0; im_addr = '0; im_wdata = '0;
    dm_we = 1'b0; dm_addr = '0; dm_wdata = '0;

    for (int i = 0; i < (1 << IA_W); i++) im_put(i, 32'h0, 32'h0);
    // slot0 | slot1
    im_put(0,  iop(T_ADDI, 0, 1, 16),  iop(T_LW, 0, 2, 0));
    im_put(1,  iop(T_ADDI, 0, 3, -1),  iop(T_LW, 0, 4, 4));
    im_put(2,  rop(2, 4, 5, F_ADDU),   iop(T_SW, 0, 1, 64));
    im_put(3,  rop(3, 1, 6, F_SUBU),   iop(T_SW, 0, 5, 68));
    im_put(4,  rop(6, 1, 7, F_SLT),    iop(T_SW, 0, 6, 72));
    im_put(5,  rop(3, 5, 8, F_AND),    iop(T_SW, 0, 7, 76));
    im_put(6,  rop(1, 4, 9, F_OR),     iop(T_SW, 0, 8, 80));
    im_put(7,  iop(T_ADDI, 9, 9, 1),   iop(T_SW, 0, 9, 84));
    im_put(8,  iop(T_ADDI, 0, 10, 55), iop(T_LW, 0, 10, 8));
    im_put(9,  iop(T_ADDI, 0, 0, 9),   iop(T_SW, 0, 10, 88));
    im_put(10, iop(T_LW, 0, 1, 0),     rop(0, 0, 1, F_ADDU));
    im_put(11, iop(T_ADDI, 0, 12, 3),  iop(T_SW, 0, 0, 92));
    im_put(12, iop(T_BNE, 12, 0, 2),   iop(T_SW, 0, 1, 96));
    im_put(13, iop(T_ADDI, 0, 13, 1),  iop(T_SW, 0, 1, 100));
    im_put(14, iop(T_BEQ, 12, 0, 4),   iop(T_SW, 0, 12, 104));
    im_put(15, iop(T_BEQ, 0, 0, -2),   32'h0);

    dm_put(0, 32'd5);
    dm_put(1, 32'd7);
    dm_put(2, 32'hFFFFFFFD);
    dm_put(3, 32'd100);

    // R1: quiet during reset
    repeat (3) @(negedge clk);
    total++;
    if (store_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: store_valid in reset actual=%0b expected=0", store_valid);
    end

    // run 1: no stalls
    push_program();
    @(negedge clk);
    rst = 1'b0;
    drain("R1");

    // run 2: restart from reset with stall bursts
    rst = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (store_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: store_valid in second reset actual=%0b expected=0", store_valid);
    end
    push_program();
    rst = 1'b0;
    for (int c = 0; c < 90; c++) begin
      @(negedge clk);
      stall = ((c % 4) == 1) || ((c % 7) == 3) || (c >= 20 && c < 26);
    end
    @(negedge clk);
    stall = 1'b0;
    drain("R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule